// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two ALU operands of an in-order, five-stage pipeline comes from. It takes the two source register numbers of the instruction now in the execute stage. It compares them with the destination register numbers held further down the pipe: one in the register after execute, one in the register after the memory stage. When a younger result is still in flight, the block redirects the operand to that result instead of the stale register-file read.

The selector is purely combinational. A thin wrapper holds the two operand multiplexers, so the block delivers both the 2-bit select codes and the chosen operand data. The producer nearest to the execute stage always wins. Register zero is never bypassed. Each stage's producer is ignored while its write enable is low.

Top module: `opnd_bypass_unit`

## Requirements
- R1: `fwd_sel0` is 2'b10 whenever `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals `exe_src0_idx`.
- R2: `fwd_sel1` is 2'b10 whenever `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals `exe_src1_idx`.
- R3: A select is 2'b01 when `wb_wr_en` is 1, `wb_dst_idx` is nonzero and it equals that operand's source number, provided the R1/R2 condition for that same operand is false.
- R4: When both later stages match one operand with valid, nonzero destinations, the select is 2'b10 (the newer memory-stage result wins).
- R5: A stage whose write enable is 0 never causes a select code pointing at it.
- R6: A destination number of 0 never causes forwarding, even when it equals the source number.
- R7: When no forwarding condition holds, the select is 2'b00; the code 2'b11 is never produced and the multiplexer treats it like 2'b00.
- R8: Operand data follows the select: 2'b10 gives `mem_alu_data`, 2'b01 gives `wb_wr_data`, 2'b00 gives that operand's register-file read data.
- R9: The two operands are resolved independently, so in one cycle they may take different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exe_src0_idx | input | REG_W | First source register number of the execute-stage instruction |
| exe_src1_idx | input | REG_W | Second source register number of the execute-stage instruction |
| mem_dst_idx | input | REG_W | Destination register number held after execute |
| mem_wr_en | input | 1 | That instruction writes a register |
| wb_dst_idx | input | REG_W | Destination register number held after the memory stage |
| wb_wr_en | input | 1 | That instruction writes a register |
| rf_rd0_data | input | DATA_W | Register-file read value for operand 0 |
| rf_rd1_data | input | DATA_W | Register-file read value for operand 1 |
| mem_alu_data | input | DATA_W | ALU result held after execute |
| wb_wr_data | input | DATA_W | Value about to be written back |
| fwd_sel0 | output | 2 | Source select for operand 0 |
| fwd_sel1 | output | 2 | Source select for operand 1 |
| alu_opnd0 | output | DATA_W | Selected operand 0 |
| alu_opnd1 | output | DATA_W | Selected operand 1 |

## Verification
The embedded assertions check, on every input change, several properties. The code 2'b11 never appears. A disabled or zero-numbered producer is never chosen. A memory-stage match always wins. The operand data agrees with the select. Only the bench's sweep can show that every combination of source numbers, destination numbers and enables yields exactly the expected code. That includes the cases where a wrongly widened or narrowed match would silently pick the register file. The sweep runs on a 3-bit register-number configuration, so every aliasing pattern between the two sources and two destinations is visited.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  typedef enum logic [1:0] {
    SRC_RFILE = 2'b00,
    SRC_WBACK = 2'b01,
    SRC_MSTAGE = 2'b10,
    SRC_RSVD  = 2'b11
  } opnd_src_e;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/bypass_hit.sv
module bypass_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic             prod_wen,
  input  logic [REG_W-1:0] prod_dst,
  input  logic [REG_W-1:0] cons_src,
  output logic             hit
);
  logic dst_live;

  always_comb begin
    dst_live = prod_wen && (prod_dst != '0);
    hit      = dst_live && (prod_dst == cons_src);
  end
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic [REG_W-1:0] src_idx,
  output opnd_src_e        sel
);
  logic mem_hit;
  logic wb_hit;

  bypass_hit #(.REG_W(REG_W)) u_mem_hit (
    .prod_wen(mem_wen), .prod_dst(mem_dst), .cons_src(src_idx), .hit(mem_hit)
  );

  bypass_hit #(.REG_W(REG_W)) u_wb_hit (
    .prod_wen(wb_wen), .prod_dst(wb_dst), .cons_src(src_idx), .hit(wb_hit)
  );

  always_comb begin
    if (mem_hit)     sel = SRC_MSTAGE;
    else if (wb_hit) sel = SRC_WBACK;
    else             sel = SRC_RFILE;
  end

  always_comb begin
    if (src_idx == '0) begin
      assert_zero_src_R6: assert (sel == SRC_RFILE)
        else $error("register zero forwarded");
    end
    if (mem_hit) begin
      assert_newest_wins_R4: assert (sel == SRC_MSTAGE)
        else $error("memory-stage match lost priority");
    end
  end
endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opnd_src_e         sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_MSTAGE: opnd = mem_val;
      SRC_WBACK:  opnd = wb_val;
      default:    opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/opnd_bypass_unit.sv
module opnd_bypass_unit
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_W-1:0]  exe_src0_idx,
  input  logic [REG_W-1:0]  exe_src1_idx,
  input  logic [REG_W-1:0]  mem_dst_idx,
  input  logic              mem_wr_en,
  input  logic [REG_W-1:0]  wb_dst_idx,
  input  logic              wb_wr_en,
  input  logic [DATA_W-1:0] rf_rd0_data,
  input  logic [DATA_W-1:0] rf_rd1_data,
  input  logic [DATA_W-1:0] mem_alu_data,
  input  logic [DATA_W-1:0] wb_wr_data,
  output logic [1:0]        fwd_sel0,
  output logic [1:0]        fwd_sel1,
  output logic [DATA_W-1:0] alu_opnd0,
  output logic [DATA_W-1:0] alu_opnd1
);
  logic [NUM_OPND-1:0][REG_W-1:0]  src_vec;
  logic [NUM_OPND-1:0][DATA_W-1:0] rf_vec;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnd_vec;
  opnd_src_e                       sel_vec [NUM_OPND];

  assign src_vec[0] = exe_src0_idx;
  assign src_vec[1] = exe_src1_idx;
  assign rf_vec[0]  = rf_rd0_data;
  assign rf_vec[1]  = rf_rd1_data;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    bypass_pick #(.REG_W(REG_W)) u_pick (
      .mem_wen(mem_wr_en), .mem_dst(mem_dst_idx),
      .wb_wen(wb_wr_en),   .wb_dst(wb_dst_idx),
      .src_idx(src_vec[g]), .sel(sel_vec[g])
    );
    opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel_vec[g]), .rf_val(rf_vec[g]), .mem_val(mem_alu_data),
      .wb_val(wb_wr_data), .opnd(opnd_vec[g])
    );
  end

  assign fwd_sel0  = sel_vec[0];
  assign fwd_sel1  = sel_vec[1];
  assign alu_opnd0 = opnd_vec[0];
  assign alu_opnd1 = opnd_vec[1];

  always_comb begin
    assert_no_rsvd_code_R7: assert (fwd_sel0 != 2'b11 && fwd_sel1 != 2'b11)
      else $error("reserved select produced");
    if (!mem_wr_en) begin
      assert_mem_off_R5: assert (fwd_sel0 != 2'b10 && fwd_sel1 != 2'b10)
        else $error("disabled memory stage selected");
    end
    if (!wb_wr_en) begin
      assert_wb_off_R5: assert (fwd_sel0 != 2'b01 && fwd_sel1 != 2'b01)
        else $error("disabled writeback stage selected");
    end
    if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == exe_src0_idx) begin
      assert_mem_hit_a_R1: assert (fwd_sel0 == 2'b10)
        else $error("operand 0 missed memory-stage match");
    end
    if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == exe_src1_idx) begin
      assert_mem_hit_b_R2: assert (fwd_sel1 == 2'b10)
        else $error("operand 1 missed memory-stage match");
    end
    if (fwd_sel0 == 2'b10) begin
      assert_data_a_R8: assert (alu_opnd0 == mem_alu_data)
        else $error("operand 0 data disagrees with select");
    end
    if (fwd_sel1 == 2'b01) begin
      assert_data_b_R8: assert (alu_opnd1 == wb_wr_data)
        else $error("operand 1 data disagrees with select");
    end
  end
endmodule

// File: tb/sim_opnd_bypass_unit.sv
module sim_opnd_bypass_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] s0, s1, md, wd;
  logic          me, we;
  logic [DW-1:0] r0, r1, mv, wv;
  logic [1:0]    sel0, sel1;
  logic [DW-1:0] o0, o1;

  int n_chk = 0;
  int n_bad = 0;

  opnd_bypass_unit #(.REG_W(RW), .DATA_W(DW)) u0 (
    .exe_src0_idx(s0), .exe_src1_idx(s1), .mem_dst_idx(md), .mem_wr_en(me),
    .wb_dst_idx(wd), .wb_wr_en(we), .rf_rd0_data(r0), .rf_rd1_data(r1),
    .mem_alu_data(mv), .wb_wr_data(wv), .fwd_sel0(sel0), .fwd_sel1(sel1),
    .alu_opnd0(o0), .alu_opnd1(o1)
  );

  function automatic logic [1:0] exp_sel(logic [RW-1:0] s);
    logic mh, wh;
    mh = me && (md != 0) && (md == s);
    wh = we && (wd != 0) && (wd == s);
    if (mh) return 2'b10;
    if (wh) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(logic [RW-1:0] s, int op);
    logic mmatch, wmatch;
    mmatch = (md == s);
    wmatch = (wd == s);
    if (s == 0 && (mmatch || wmatch)) return "R6";
    if ((mmatch && !me) || (wmatch && !we)) return "R5";
    if (me && mmatch && we && wmatch) return "R4";
    if (me && mmatch) return (op == 0) ? "R1" : "R2";
    if (we && wmatch) return "R3";
    return "R7";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (s0=%0d s1=%0d md=%0d me=%0b wd=%0d we=%0b)",
               tag, act, exp, s0, s1, md, me, wd, we);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] e0, e1;
    s0 = '0; s1 = '0; md = '0; wd = '0; me = 1'b0; we = 1'b0;
    r0 = 16'h1111; r1 = 16'h2222; mv = 16'h3333; wv = 16'h4444;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: idle inputs select the register file
    chk("R7 idle sel0", sel0, 2'b00);
    chk("R7 idle sel1", sel1, 2'b00);
    chk("R8 idle opnd0", o0, 16'h1111);
    chk("R8 idle opnd1", o1, 16'h2222);

    for (int v = 0; v < (1 << (4*RW + 2)); v++) begin
      @(negedge clk);
      s0 = v[RW-1:0];
      s1 = v[2*RW-1:RW];
      md = v[3*RW-1:2*RW];
      wd = v[4*RW-1:3*RW];
      me = v[4*RW];
      we = v[4*RW+1];
      r0 = {4'h1, v[11:0]};
      r1 = {4'h2, v[11:0]};
      mv = {4'h3, v[11:0]};
      wv = {4'h4, v[11:0]};
      #(CLK_PERIOD/4);
      e0 = exp_sel(s0);
      e1 = exp_sel(s1);
      chk({tag_for(s0, 0), " sel0"}, sel0, e0);
      chk({tag_for(s1, 1), " sel1"}, sel1, e1);
      // R8/R9: each operand's data follows its own select
      chk("R8/R9 opnd0", o0, (e0 == 2'b10) ? mv : (e0 == 2'b01) ? wv : r0);
      chk("R8/R9 opnd1", o1, (e1 == 2'b10) ? mv : (e1 == 2'b01) ? wv : r1);
    end

    // R9: directed case, operands take different sources in one cycle
    @(negedge clk);
    s0 = 3'd5; s1 = 3'd6; md = 3'd5; me = 1'b1; wd = 3'd6; we = 1'b1;
    #(CLK_PERIOD/4);
    chk("R9 split sel0", sel0, 2'b10);
    chk("R9 split sel1", sel1, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule